// File: doc/BRIEF.md
# Write Completion Polling Controller

This block sits on the host side of a nonvolatile memory and decides when an internal program or erase cycle has finished. A single-cycle start pulse hands it the operation kind (program or erase), the target address, the byte that was programmed and a read budget. From then on it fetches status bytes from that address over a plain request/acknowledge read port and judges each one by one of two methods chosen at start: the bit 7 polarity method or the bit 6 alternation method.

A status byte can be fetched at the very moment the memory finishes, so it may show a completed status bit while the other bits are not yet right. When that happens the controller fetches the same location twice more and accepts completion only if both bytes are right. After an accepted completion it stays quiet for a set number of cycles, standing for the recovery interval of the memory, and then fetches the final byte that it reports.

The outcome is given as a one-cycle done or error pulse and a status that holds until the next accepted start: a two-bit result code and the last byte fetched.

Top module: `wr_poll_ctrl`

## Requirements
- R1: Bit 7 method, program: a fetched byte whose bit 7 equals bit 7 of the programmed byte shows the cycle has stopped; one whose bit 7 differs shows it is still running and the next status fetch follows.
- R2: Bit 7 method, erase: the programmed-byte input is ignored, the good byte is 8'hFF, and the cycle has stopped when the fetched bit 7 is 1.
- R3: Bit 6 method: the cycle has stopped when bit 6 of a fetched byte equals bit 6 of the byte fetched just before it in the same poll; the first status byte never shows a stop.
- R4: When a byte shows a stop but differs from the good byte (programmed byte, or 8'hFF for erase), two more bytes are fetched from the same address; if both equal the good byte the completion is accepted, otherwise the poll ends rejected.
- R5: When the number of status fetches that showed a running cycle reaches the read budget (at least 1), the poll ends with a timeout.
- R6: Result codes in stat_code are 2'b00 none, 2'b01 done, 2'b10 rejected, 2'b11 timeout; an accepted start sets 2'b00; done pulses for one cycle with code 01, err pulses for one cycle with code 10 or 11, never both together, and the code and byte hold until the next accepted start.
- R7: A start pulse that arrives while busy is high is ignored: address, method and expected byte of the running poll are kept.
- R8: After an accepted completion, rd_req stays low for exactly SETTLE_CYC cycles, then one more byte is fetched; that byte is reported in stat_byte with done.
- R9: rd_req stays high with a stable rd_addr until rd_ack, and one fetch ends before the next begins; a fetch completes in the cycle where rd_req and rd_ack are both high.
- R10: After reset busy, rd_req, done and err are low and stat_code is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a poll |
| op_erase | input | 1 | 1 erase, 0 program |
| use_toggle | input | 1 | 1 bit 6 method, 0 bit 7 method |
| tgt_addr | input | AW | Address to poll |
| prog_byte | input | 8 | Byte that was programmed |
| max_reads | input | TW | Budget of running-status fetches |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge, rd_data valid |
| rd_data | input | 8 | Fetched byte |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle reject or timeout pulse |
| stat_code | output | 2 | Result code |
| stat_byte | output | 8 | Last fetched byte |

## Verification
On every cycle the assertions hold the read handshake steady until acknowledge, keep the address fixed across a start pulse that lands during a poll, keep done and err apart and one cycle long, and tie each pulse to its result code. Only the directed scenarios can show the judging of byte sequences: which fetch ends a poll under each method, the two confirming fetches with their pass and reject outcomes, the exact fetch count at timeout and the length of the quiet gap before the final fetch.

// File: rtl/wr_poll_ctrl.sv
module wr_poll_ctrl #(
  parameter int AW = 24,
  parameter int TW = 16,
  parameter int SETTLE_CYC = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic          use_toggle,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    prog_byte,
  input  logic [TW-1:0] max_reads,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    stat_code,
  output logic [7:0]    stat_byte
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_POLL, S_CONF1, S_CONF2, S_SETTLE, S_FINAL} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [7:0]    good_q, prev_q, byte_q;
  logic          tog_q, prev_v, conf_ok;
  logic [TW-1:0] rcnt, max_q;
  logic [SW-1:0] scnt;
  logic [1:0]    code_q;
  logic          done_q, err_q;

  wire          got     = rd_req & rd_ack;
  wire          stopped = tog_q ? (prev_v && (rd_data[6] == prev_q[6])) : (rd_data[7] == good_q[7]);
  wire          match   = (rd_data == good_q);
  wire [TW:0]   rnext   = {1'b0, rcnt} + 1'b1;

  assign rd_req    = (st == S_POLL) || (st == S_CONF1) || (st == S_CONF2) || (st == S_FINAL);
  assign rd_addr   = addr_q;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign stat_code = code_q;
  assign stat_byte = byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr_q <= '0;
      good_q <= '0;
      prev_q <= '0;
      byte_q <= '0;
      tog_q <= 1'b0;
      prev_v <= 1'b0;
      conf_ok <= 1'b0;
      rcnt <= '0;
      max_q <= '0;
      scnt <= '0;
      code_q <= 2'b00;
      done_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr_q <= tgt_addr;
          good_q <= op_erase ? 8'hFF : prog_byte;
          tog_q  <= use_toggle;
          max_q  <= max_reads;
          rcnt   <= '0;
          prev_v <= 1'b0;
          code_q <= 2'b00;
          st     <= S_POLL;
        end
        S_POLL: if (got) begin
          prev_q <= rd_data;
          prev_v <= 1'b1;
          byte_q <= rd_data;
          if (stopped && match) begin
            scnt <= '0;
            st   <= S_SETTLE;
          end else if (stopped) begin
            st <= S_CONF1;
          end else begin
            rcnt <= rnext[TW-1:0];
            if (rnext >= {1'b0, max_q}) begin
              code_q <= 2'b11;
              err_q  <= 1'b1;
              st     <= S_IDLE;
            end
          end
        end
        S_CONF1: if (got) begin
          byte_q  <= rd_data;
          conf_ok <= match;
          st      <= S_CONF2;
        end
        S_CONF2: if (got) begin
          byte_q <= rd_data;
          if (conf_ok && match) begin
            scnt <= '0;
            st   <= S_SETTLE;
          end else begin
            code_q <= 2'b10;
            err_q  <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_SETTLE: begin
          if (scnt == SW'(SETTLE_CYC - 1)) st <= S_FINAL;
          else scnt <= scnt + 1'b1;
        end
        S_FINAL: if (got) begin
          byte_q <= rd_data;
          code_q <= 2'b01;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  a_r7_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> $stable(rd_addr));

  a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n) err |=> !err);

  a_r6_done_code: assert property (@(posedge clk) disable iff (!rst_n) done |-> stat_code == 2'b01);

  a_r6_err_code: assert property (@(posedge clk) disable iff (!rst_n) err |-> stat_code[1]);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !rd_req);
endmodule

// File: tb/wr_poll_ctrl_tb.sv
module wr_poll_ctrl_tb;
  localparam int AW = 24;
  localparam int TW = 16;
  localparam int SETTLE = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_erase = 1'b0, use_toggle = 1'b0;
  logic [AW-1:0] tgt_addr = '0;
  logic [7:0] prog_byte = '0;
  logic [TW-1:0] max_reads = '0;
  logic rd_req, rd_ack = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic busy, done, err;
  logic [1:0] stat_code;
  logic [7:0] stat_byte;

  int checks = 0, fails = 0;
  logic [7:0] resp [16];
  int nresp = 0, base = 0, nreads = 0, lowbase = 0, lowcnt = 0;
  logic [7:0] tail = '0;

  always #10 clk = ~clk;

  wr_poll_ctrl #(.AW(AW), .TW(TW), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase), .use_toggle(use_toggle),
    .tgt_addr(tgt_addr), .prog_byte(prog_byte), .max_reads(max_reads),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .done(done), .err(err), .stat_code(stat_code), .stat_byte(stat_byte));

  always @(posedge clk) begin : responder
    int k;
    if (rd_req && !rd_ack) begin
      k = nreads - base;
      rd_ack <= 1'b1;
      rd_data <= (k < nresp) ? resp[k] : tail;
      nreads <= nreads + 1;
    end else begin
      rd_ack <= 1'b0;
    end
    if (busy && !rd_req) lowcnt <= lowcnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go(input bit er, input bit tg, input logic [7:0] pb, input int mr, input logic [AW-1:0] ad);
    @(negedge clk);
    base = nreads;
    lowbase = lowcnt;
    op_erase = er; use_toggle = tg; prog_byte = pb; max_reads = TW'(mr); tgt_addr = ad;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    do @(negedge clk); while (!(done || err));
  endtask

  task automatic t_reset();
    chk(stat_code == 2'b00 && !busy && !rd_req && !done && !err, "R10", {stat_code, busy, rd_req, done, err}, 0);
  endtask

  task automatic t_poll_prog();
    resp[0] = 8'hA5; resp[1] = 8'hA5; resp[2] = 8'hA5; resp[3] = 8'h5A; nresp = 4; tail = 8'h5A;
    go(1'b0, 1'b0, 8'h5A, 20, 24'h001000);
    chk(rd_addr == 24'h001000, "R9", rd_addr, 24'h001000);
    wait_end();
    chk(done && stat_code == 2'b01, "R1", stat_code, 1);
    chk(stat_byte == 8'h5A, "R8", stat_byte, 8'h5A);
    chk(nreads - base == 5, "R1", nreads - base, 5);
    chk(lowcnt - lowbase == SETTLE, "R8", lowcnt - lowbase, SETTLE);
    repeat (5) @(negedge clk);
    chk(stat_code == 2'b01 && !done, "R6", stat_code, 1);
  endtask

  task automatic t_poll_erase();
    resp[0] = 8'h00; resp[1] = 8'h00; resp[2] = 8'hFF; nresp = 3; tail = 8'hFF;
    go(1'b1, 1'b0, 8'h12, 20, 24'h002000);
    wait_end();
    chk(done && stat_code == 2'b01 && stat_byte == 8'hFF, "R2", stat_byte, 8'hFF);
    chk(nreads - base == 4, "R2", nreads - base, 4);
  endtask

  task automatic t_toggle();
    resp[0] = 8'h40; resp[1] = 8'h00; resp[2] = 8'h40; resp[3] = 8'h33; resp[4] = 8'h33;
    nresp = 5; tail = 8'h33;
    go(1'b0, 1'b1, 8'h33, 20, 24'h003000);
    wait_end();
    chk(done && stat_byte == 8'h33, "R3", stat_byte, 8'h33);
    chk(nreads - base == 6, "R3", nreads - base, 6);
  endtask

  task automatic t_race_pass();
    resp[0] = 8'h00; resp[1] = 8'h8F; resp[2] = 8'h80; resp[3] = 8'h80; nresp = 4; tail = 8'h80;
    go(1'b0, 1'b0, 8'h80, 20, 24'h004000);
    wait_end();
    chk(done && stat_code == 2'b01, "R4", stat_code, 1);
    chk(nreads - base == 5, "R4", nreads - base, 5);
    chk(lowcnt - lowbase == SETTLE, "R8", lowcnt - lowbase, SETTLE);
  endtask

  task automatic t_race_reject();
    resp[0] = 8'h8F; resp[1] = 8'h11; resp[2] = 8'h80; nresp = 3; tail = 8'h80;
    go(1'b0, 1'b0, 8'h80, 20, 24'h005000);
    wait_end();
    chk(err && !done && stat_code == 2'b10, "R4", stat_code, 2);
    chk(nreads - base == 3 && stat_byte == 8'h80, "R4", nreads - base, 3);
  endtask

  task automatic t_timeout();
    nresp = 0; tail = 8'hA5;
    go(1'b0, 1'b0, 8'h5A, 3, 24'h006000);
    chk(stat_code == 2'b00, "R6", stat_code, 0);
    wait_end();
    chk(err && stat_code == 2'b11, "R5", stat_code, 3);
    chk(nreads - base == 3, "R5", nreads - base, 3);
    chk(stat_byte == 8'hA5, "R5", stat_byte, 8'hA5);
  endtask

  task automatic t_ignore_start();
    resp[0] = 8'hA5; resp[1] = 8'hA5; resp[2] = 8'hA5; resp[3] = 8'hA5; resp[4] = 8'h5A;
    nresp = 5; tail = 8'h5A;
    go(1'b0, 1'b0, 8'h5A, 20, 24'h007000);
    @(negedge clk);
    op_erase = 1'b1; use_toggle = 1'b1; prog_byte = 8'h00; tgt_addr = 24'h00ABCD; max_reads = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(rd_addr == 24'h007000, "R7", rd_addr, 24'h007000);
    wait_end();
    chk(done && stat_byte == 8'h5A, "R7", stat_byte, 8'h5A);
    chk(nreads - base == 6, "R7", nreads - base, 6);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_poll_prog();
    t_poll_erase();
    t_toggle();
    t_race_pass();
    t_race_reject();
    t_timeout();
    t_ignore_start();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule